// File: doc/BRIEF.md
# Read-Guarded State Register Pair

This block holds an 8-bit control and state register that two parties change: a host on a simple synchronous register bus, and logic inside the device through a per-bit update port. A shadow comparison register sits beside it. Each host read of the state register copies the state value into the shadow. A later host write to the state register changes only the bits that still equal their shadow copy. A bit that the device changed after the host last read it keeps its value. This stops the host from overwriting a change it has not yet seen.

When a write to the state register is blocked on any bit, a sticky inhibit flag is set. The flag is visible in an interrupt condition register and on an output pin. The host clears it by writing 1 to its bit. The host can read and write the shadow register directly, so it can force the protection on or release it.

Field layout of both registers: bits 2:0 transmit mode, bits 4:3 injection control, bit 5 smoother enable, bit 6 request-data parity enable, bit 7 reserved. The block does not interpret these fields.

Top module: `wrguard_regpair`

## Requirements
- R1: Reset clears the state register, the shadow register and the inhibit flag to 0. The two registers then match, so the first host write to the state register is fully accepted.
- R2: A read strobe at the state address (default 0x1A) copies the state value present before that clock edge into the shadow register.
- R3: In a host write to the state address, every bit whose state value equals its shadow value takes the written data. This happens even when other bits in the same write are blocked.
- R4: In a host write to the state address, every bit whose state value differs from its shadow value keeps its current value.
- R5: The inhibit flag is set to 1 at the clock edge of a state write that has at least one blocked bit. A state write with no blocked bit leaves the flag unchanged. Nothing other than a state write sets the flag.
- R6: The inhibit flag stays 1 until the host writes to the interrupt condition address (default 0x1C) with data bit 0 equal to 1. Writing 0 in bit 0 has no effect. If an inhibit occurs in the same cycle as a clear, the inhibit wins.
- R7: For each bit i with update enable devWe[i]=1, the state bit takes devData[i] at the next edge, whatever the bus is doing. If a host state write hits the same bit in that cycle, the device value wins and the bit counts as blocked.
- R8: The host can read the shadow register at the shadow address (default 0x1B), and a write there replaces all 8 shadow bits with the written data.
- R9: Each bit accepted by a host state write also copies its new value into the shadow. A host's own writes therefore never block its next write.
- R10: While the read strobe is high, busRdata combinationally returns the state register at 0x1A, the shadow register at 0x1B, or the flag in bit 0 with bits 7:1 zero at 0x1C. Any other address, or a low read strobe, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| devWe | input | 8 | Per-bit update enable from device logic |
| devData | input | 8 | Update values from device logic |
| stateQ | output | 8 | Current state register value for device logic |
| inhibitFlag | output | 1 | Sticky conditional-write-inhibit flag |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. Under that assumption, a snapshot can never race a direct write to the shadow register. The bench keeps to this rule by issuing at most one bus operation per cycle. It picks the operation kind at random, and it draws device updates independently as sparse one-hot masks. These updates often land in the same cycle as a host write and so exercise the collision rule. Reset state, the clear protocol and the forced-protection cases are driven in directed sequences before the random phase.

// File: rtl/wrguard_pkg.sv
package wrguard_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_STATE, RD_CMP, RD_FLAG} rdSel_t;

  typedef struct packed {
    logic   snapState;
    logic   wrState;
    logic   wrCmp;
    logic   wrFlag;
    rdSel_t rdSel;
  } strobes_t;
endpackage

// File: rtl/wrguard_ctrl.sv
module wrguard_ctrl
  import wrguard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 'h1A,
  parameter logic [ADDR_W-1:0] CMP_ADDR   = 'h1B,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 'h1C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output strobes_t          strb
);
  logic hitState, hitCmp, hitFlag;

  always_comb begin
    hitState = (busAddr == STATE_ADDR);
    hitCmp   = (busAddr == CMP_ADDR);
    hitFlag  = (busAddr == FLAG_ADDR);

    strb.snapState = busRd & hitState;
    strb.wrState   = busWr & hitState;
    strb.wrCmp     = busWr & hitCmp;
    strb.wrFlag    = busWr & hitFlag;

    if (!busRd)        strb.rdSel = RD_NONE;
    else if (hitState) strb.rdSel = RD_STATE;
    else if (hitCmp)   strb.rdSel = RD_CMP;
    else if (hitFlag)  strb.rdSel = RD_FLAG;
    else               strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/wrguard_dp.sv
module wrguard_dp
  import wrguard_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] devWe,
  input  logic [DATA_W-1:0] devData,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] stateQ,
  output logic [DATA_W-1:0] cmpQ,
  output logic              inhibitFlag
);
  logic [DATA_W-1:0] guardMask, acceptMask, blockMask;
  logic [DATA_W-1:0] stateNext, cmpNext;
  logic              flagNext, inhibitEvent;

  always_comb begin
    // a bit is guarded when it drifted from the snapshot or the device owns it now
    guardMask  = (stateQ ^ cmpQ) | devWe;
    acceptMask = strb.wrState ? ~guardMask : '0;
    blockMask  = strb.wrState ?  guardMask : '0;
    inhibitEvent = |blockMask;

    stateNext = (stateQ & ~devWe & ~acceptMask)
              | (devData & devWe)
              | (busWdata & acceptMask);

    if (strb.wrCmp)          cmpNext = busWdata;
    else if (strb.snapState) cmpNext = stateQ;
    else                     cmpNext = (cmpQ & ~acceptMask) | (busWdata & acceptMask);

    if (inhibitEvent)                          flagNext = 1'b1;
    else if (strb.wrFlag && busWdata[FLAG_BIT]) flagNext = 1'b0;
    else                                        flagNext = inhibitFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= '0;
      cmpQ        <= '0;
      inhibitFlag <= 1'b0;
    end else begin
      stateQ      <= stateNext;
      cmpQ        <= cmpNext;
      inhibitFlag <= flagNext;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strb.rdSel)
      RD_STATE: busRdata = stateQ;
      RD_CMP:   busRdata = cmpQ;
      RD_FLAG:  busRdata[FLAG_BIT] = inhibitFlag;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wrguard_regpair.sv
module wrguard_regpair
  import wrguard_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 0,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 'h1A,
  parameter logic [ADDR_W-1:0] CMP_ADDR   = 'h1B,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] devWe,
  input  logic [DATA_W-1:0] devData,
  output logic [DATA_W-1:0] stateQ,
  output logic              inhibitFlag
);
  strobes_t          strb;
  logic [DATA_W-1:0] cmpVal;

  wrguard_ctrl #(
    .ADDR_W(ADDR_W), .STATE_ADDR(STATE_ADDR),
    .CMP_ADDR(CMP_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .strb(strb)
  );

  wrguard_dp #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .devWe(devWe), .devData(devData), .busRdata(busRdata),
    .stateQ(stateQ), .cmpQ(cmpVal), .inhibitFlag(inhibitFlag)
  );
endmodule

// File: rtl/wrguard_chk.sv
module wrguard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 'h1A,
  parameter logic [ADDR_W-1:0] CMP_ADDR   = 'h1B,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 'h1C
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] devWe,
  input logic [DATA_W-1:0] devData,
  input logic [DATA_W-1:0] stateQ,
  input logic [DATA_W-1:0] cmpVal,
  input logic              inhibitFlag
);
  // bus rule taken for granted by the other properties
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R2
  snapshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == STATE_ADDR) |=> (cmpVal == $past(stateQ)));

  // R4
  guarded_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == STATE_ADDR) |=>
      (((stateQ ^ $past(stateQ)) & $past(stateQ ^ cmpVal) & ~$past(devWe)) == '0));

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibitFlag && !(busWr && busAddr == STATE_ADDR)) |=> !inhibitFlag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inhibitFlag && !(busWr && busAddr == FLAG_ADDR)) |=> inhibitFlag);

  // R7
  dev_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devWe != '0) |=> (((stateQ ^ $past(devData)) & $past(devWe)) == '0));

  // R8
  cmp_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == CMP_ADDR) |=> (cmpVal == $past(busWdata)));
endmodule

bind wrguard_regpair wrguard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATE_ADDR(STATE_ADDR),
  .CMP_ADDR(CMP_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busWdata(busWdata), .devWe(devWe), .devData(devData), .stateQ(stateQ),
  .cmpVal(cmpVal), .inhibitFlag(inhibitFlag)
);

// File: tb/wrguard_regpair_bench.sv
module wrguard_regpair_bench;
  localparam logic [7:0] A_STATE = 8'h1A;
  localparam logic [7:0] A_CMP   = 8'h1B;
  localparam logic [7:0] A_FLAG  = 8'h1C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0, devWe = '0, devData = '0;
  logic       busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busRdata, stateQ;
  logic       inhibitFlag;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  logic [7:0] refState = '0, refCmp = '0;
  logic       refFlag = 1'b0;

  always #5 clk = ~clk;

  wrguard_regpair u_wrguard_regpair (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .devWe(devWe), .devData(devData),
    .stateQ(stateQ), .inhibitFlag(inhibitFlag)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [7:0] a);
    if (a == A_STATE)     return refState;
    else if (a == A_CMP)  return refCmp;
    else if (a == A_FLAG) return {7'b0, refFlag};
    else                  return 8'h00;
  endfunction

  // one cycle: drive after a falling edge, check read data, clock, check state
  task automatic step(string req, logic [7:0] a, logic rd, logic wr, logic [7:0] wd,
                      logic [7:0] dwe, logic [7:0] dd);
    logic [7:0] drift, okBits;
    logic       blocked;
    busAddr = a; busRd = rd; busWr = wr; busWdata = wd; devWe = dwe; devData = dd;
    #1;
    check({req, " R10 read data"}, busRdata, rd ? expRead(a) : 8'h00);
    drift   = (refState ^ refCmp) | dwe;
    okBits  = (wr && a == A_STATE) ? ~drift : 8'h00;
    blocked = wr && a == A_STATE && drift != 8'h00;
    if (wr && a == A_CMP)        refCmp = wd;
    else if (rd && a == A_STATE) refCmp = refState;
    else                         refCmp = (refCmp & ~okBits) | (wd & okBits);
    refState = (refState & ~dwe & ~okBits) | (dd & dwe) | (wd & okBits);
    if (blocked) refFlag = 1'b1;
    else if (wr && a == A_FLAG && wd[0]) refFlag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    busRd = 0; busWr = 0; devWe = '0;
    check({req, " state"}, stateQ, refState);
    check({req, " flag"}, {7'b0, inhibitFlag}, {7'b0, refFlag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 state after reset", stateQ, 8'h00);
    check("R1 flag after reset", {7'b0, inhibitFlag}, 8'h00);
    step("R1 shadow after reset", A_CMP, 1, 0, 0, 0, 0);
    step("R1 first write accepted", A_STATE, 0, 1, 8'h5A, 0, 0);
    check("R1 first write", stateQ, 8'h5A);
    check("R1 no inhibit", {7'b0, inhibitFlag}, 8'h00);
    // R2 snapshot then device change
    step("R2 snapshot read", A_STATE, 1, 0, 0, 0, 0);
    step("R7 device sets bit0", 8'h00, 0, 0, 0, 8'h01, 8'h01);
    check("R7 device bit", stateQ, 8'h5B);
    step("R3 R4 partial write", A_STATE, 0, 1, 8'h00, 0, 0);
    check("R4 drifted bit kept, R3 others cleared", stateQ, 8'h01);
    check("R5 flag set", {7'b0, inhibitFlag}, 8'h01);
    step("R6 write 0 no clear", A_FLAG, 0, 1, 8'h00, 0, 0);
    check("R6 flag still set", {7'b0, inhibitFlag}, 8'h01);
    step("R10 flag read", A_FLAG, 1, 0, 0, 0, 0);
    step("R6 clear", A_FLAG, 0, 1, 8'h01, 0, 0);
    check("R6 flag cleared", {7'b0, inhibitFlag}, 8'h00);
    // R8 release protection by writing the shadow
    step("R8 shadow write", A_CMP, 0, 1, 8'h01, 0, 0);
    step("R8 shadow readback", A_CMP, 1, 0, 0, 0, 0);
    step("R8 released write", A_STATE, 0, 1, 8'hFE, 0, 0);
    check("R8 full write", stateQ, 8'hFE);
    check("R5 clean write leaves flag", {7'b0, inhibitFlag}, 8'h00);
    // R9 own writes do not self-lock
    step("R9 back-to-back write", A_STATE, 0, 1, 8'h33, 0, 0);
    check("R9 second write accepted", stateQ, 8'h33);
    check("R9 no inhibit", {7'b0, inhibitFlag}, 8'h00);
    // R7 collision: device wins, counts as blocked
    step("R7 collision", A_STATE, 0, 1, 8'hFF, 8'h80, 8'h00);
    check("R7 device wins", stateQ, 8'h7F);
    check("R7 collision inhibits", {7'b0, inhibitFlag}, 8'h01);
    step("R10 unmapped read", 8'h05, 1, 0, 0, 0, 0);
    step("R6 clear again", A_FLAG, 0, 1, 8'hFF, 0, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] dwe, dd, wd;
      op  = int'($urandom % 7);
      wd  = 8'($urandom);
      dd  = 8'($urandom);
      dwe = ($urandom % 4 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
      case (op)
        0: step("R2 rand read state", A_STATE, 1, 0, 0, dwe, dd);
        1, 2: step("R3 R4 R5 rand write state", A_STATE, 0, 1, wd, dwe, dd);
        3: step("R8 rand write shadow", A_CMP, 0, 1, wd, dwe, dd);
        4: step("R8 rand read shadow", A_CMP, 1, 0, 0, dwe, dd);
        5: step("R6 rand flag write", A_FLAG, 0, 1, wd, dwe, dd);
        default: step("R10 rand read", 8'($urandom % 32), 1, 0, 0, dwe, dd);
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule